// File: doc/BRIEF.md
# Console Keyboard and Display Register Block

This block sits on a processor's word-wide load/store bus and gives software four registers for a byte-wide console. Two registers face a keyboard source and two face a display sink. A keyboard byte arrives as a one-cycle valid strobe with its data. The block latches the byte and raises a receive-ready flag. A load from the receive data register returns the byte and clears that flag. A store to the transmit data register hands a byte to the display and holds the transmit-ready flag low until the display answers with a done pulse.

Each control register holds one read-only ready flag (bit 0) and one writable interrupt-enable (bit 1). One interrupt line goes high when either direction has its flag and its enable both set. Two small state machines carry the handshakes. The receiver has the states RX_EMPTY and RX_FULL. It moves RX_EMPTY→RX_FULL on an arrival and RX_FULL→RX_EMPTY on a data load with no arrival in the same cycle. The transmitter has the states TX_IDLE and TX_SEND. It moves TX_IDLE→TX_SEND on a data store and TX_SEND→TX_IDLE on a done pulse.

Top module: `console_mmio_regs`

## Requirements
- R1: After reset the receive-ready flag and both interrupt enables are 0, the transmit-ready flag is 1, disp_valid is 0 and irq is 0.
- R2: The registers are decoded only at word-aligned addresses BASE+0x0 (receive control), BASE+0x4 (receive data, byte in bits 7:0), BASE+0x8 (transmit control) and BASE+0xC (transmit data). BASE defaults to 0xFFFF0000. In both control registers bit 0 is the ready flag and bit 1 is the interrupt enable. All other read bits are 0. A load from transmit data returns 0.
- R3: A cycle with kbd_valid high stores kbd_byte and sets receive-ready from the next cycle on. A later arrival overwrites the stored byte.
- R4: A load from receive data clears receive-ready at the next edge. If kbd_valid is high in the same cycle, receive-ready stays 1 and the new byte is stored.
- R5: A store to transmit data while transmit-ready is 1 makes disp_valid 1 and disp_byte equal to bus_wdata[7:0] from the next cycle on, with transmit-ready read as 0.
- R6: A disp_done pulse while disp_valid is 1 drops disp_valid and sets transmit-ready at the next edge. A disp_done pulse while idle has no effect.
- R7: A store to transmit data while transmit-ready is 0 is ignored. disp_byte keeps the byte being sent, and no second send follows the done pulse.
- R8: A store to a control register updates only its bit 1. Bit 0 (the ready flag) cannot be written.
- R9: irq is 1 exactly when (receive-ready and receive-enable) or (transmit-ready and transmit-enable) holds.
- R10: Accesses outside the four decoded addresses, and misaligned ones, change no state and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid in the access cycle |
| kbd_valid | input | 1 | Keyboard byte strobe |
| kbd_byte | input | 8 | Keyboard byte |
| disp_valid | output | 1 | Display byte pending |
| disp_byte | output | 8 | Byte to display |
| disp_done | input | 1 | Display finished the byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a load from receive data that lands in the same cycle as a keyboard arrival. The clear and the set then compete, and the flag must stay 1 with the newer byte. The bench holds kbd_valid and the load in one cycle. It then loads the data register again, which must return the new byte and only then clear the flag. A store to transmit data during a send, and a done pulse while idle, are also driven directly.

// File: rtl/console_pkg.sv
package console_pkg;
    typedef enum logic {RX_EMPTY, RX_FULL} rx_state_t;
    typedef enum logic {TX_IDLE, TX_SEND} tx_state_t;
    typedef enum logic [1:0] {
        SLOT_RXCTL = 2'd0,
        SLOT_RXDAT = 2'd1,
        SLOT_TXCTL = 2'd2,
        SLOT_TXDAT = 2'd3
    } slot_t;
    localparam int READY_BIT = 0;
    localparam int IE_BIT    = 1;
    localparam int NUM_SLOTS = 4;
endpackage

// File: rtl/console_decode.sv
module console_decode #(
    parameter int          ADDR_W = 32,
    parameter logic [31:0] BASE   = 32'hFFFF_0000
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        rd_hit,
    output logic [3:0]        wr_hit
);
    localparam int SLOT_LSB = 2;
    localparam logic [ADDR_W-1:0] BASE_A = BASE[ADDR_W-1:0];

    logic in_window;
    logic [1:0] slot;

    always_comb begin
        in_window = sel && (addr[ADDR_W-1:4] == BASE_A[ADDR_W-1:4])
                        && (addr[1:0] == 2'b00);
        slot = addr[SLOT_LSB+1:SLOT_LSB];
    end

    for (genvar i = 0; i < 4; i++) begin : g_slot
        assign rd_hit[i] = in_window && !we && (slot == 2'(i));
        assign wr_hit[i] = in_window &&  we && (slot == 2'(i));
    end
endmodule

// File: rtl/console_rx.sv
module console_rx
    import console_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kbd_valid,
    input  logic [BYTE_W-1:0] kbd_byte,
    input  logic              consume,
    output logic              ready,
    output logic [BYTE_W-1:0] data
);
    rx_state_t state, state_nx;
    logic [BYTE_W-1:0] hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_EMPTY;
            hold  <= '0;
        end else begin
            state <= state_nx;
            if (kbd_valid) hold <= kbd_byte;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_EMPTY: if (kbd_valid) state_nx = RX_FULL;
            RX_FULL:  if (consume && !kbd_valid) state_nx = RX_EMPTY;
            default:  state_nx = RX_EMPTY;
        endcase
    end

    always_comb begin
        ready = (state == RX_FULL);
        data  = hold;
    end
endmodule

// File: rtl/console_tx.sv
module console_tx
    import console_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              done,
    output logic              ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte
);
    tx_state_t state, state_nx;
    logic [BYTE_W-1:0] hold;
    logic take;

    always_comb take = start && (state == TX_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            hold  <= '0;
        end else begin
            state <= state_nx;
            if (take) hold <= wbyte;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE: if (start) state_nx = TX_SEND;
            TX_SEND: if (done)  state_nx = TX_IDLE;
            default: state_nx = TX_IDLE;
        endcase
    end

    always_comb begin
        ready     = (state == TX_IDLE);
        out_valid = (state == TX_SEND);
        out_byte  = hold;
    end
endmodule

// File: rtl/console_mmio_regs.sv
module console_mmio_regs
    import console_pkg::*;
#(
    parameter int          ADDR_W = 32,
    parameter int          DATA_W = 32,
    parameter int          BYTE_W = 8,
    parameter logic [31:0] BASE   = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              kbd_valid,
    input  logic [BYTE_W-1:0] kbd_byte,
    output logic              disp_valid,
    output logic [BYTE_W-1:0] disp_byte,
    input  logic              disp_done,
    output logic              irq
);
    logic [3:0] rd_hit, wr_hit;
    logic rx_ready, tx_ready, rx_ie, tx_ie;
    logic [BYTE_W-1:0] rx_data;

    console_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .sel(bus_sel), .we(bus_we), .addr(bus_addr),
        .rd_hit(rd_hit), .wr_hit(wr_hit)
    );

    console_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .kbd_valid(kbd_valid), .kbd_byte(kbd_byte),
        .consume(rd_hit[SLOT_RXDAT]),
        .ready(rx_ready), .data(rx_data)
    );

    console_tx #(.BYTE_W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .start(wr_hit[SLOT_TXDAT]), .wbyte(bus_wdata[BYTE_W-1:0]),
        .done(disp_done),
        .ready(tx_ready), .out_valid(disp_valid), .out_byte(disp_byte)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ie <= 1'b0;
            tx_ie <= 1'b0;
        end else begin
            if (wr_hit[SLOT_RXCTL]) rx_ie <= bus_wdata[IE_BIT];
            if (wr_hit[SLOT_TXCTL]) tx_ie <= bus_wdata[IE_BIT];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (1'b1)
            rd_hit[SLOT_RXCTL]: begin
                bus_rdata[READY_BIT] = rx_ready;
                bus_rdata[IE_BIT]    = rx_ie;
            end
            rd_hit[SLOT_RXDAT]: bus_rdata[BYTE_W-1:0] = rx_data;
            rd_hit[SLOT_TXCTL]: begin
                bus_rdata[READY_BIT] = tx_ready;
                bus_rdata[IE_BIT]    = tx_ie;
            end
            default: bus_rdata = '0;
        endcase
    end

    always_comb irq = (rx_ready && rx_ie) || (tx_ready && tx_ie);
endmodule

// File: rtl/console_mmio_checker.sv
module console_mmio_checker #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              kbd_valid,
    input logic              tx_wr_hit,
    input logic              rx_ready,
    input logic              tx_ready,
    input logic              rx_ie,
    input logic              tx_ie,
    input logic              disp_valid,
    input logic [BYTE_W-1:0] disp_byte,
    input logic              disp_done,
    input logic              irq
);
    a_r3_arrival_sets: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_valid |=> rx_ready);

    a_r5_store_starts: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_hit && tx_ready |=> disp_valid && !tx_ready);

    a_r6_done_returns: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && disp_done |=> tx_ready && !disp_valid);

    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && !disp_done |=> disp_valid && $stable(disp_byte));

    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ie && !tx_ie |-> !irq);
endmodule

bind console_mmio_regs console_mmio_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .kbd_valid(kbd_valid),
    .tx_wr_hit(wr_hit[3]), .rx_ready(rx_ready), .tx_ready(tx_ready),
    .rx_ie(rx_ie), .tx_ie(tx_ie), .disp_valid(disp_valid),
    .disp_byte(disp_byte), .disp_done(disp_done), .irq(irq)
);

// File: tb/tb_console_mmio_regs.sv
`timescale 1ns/1ps
module tb_console_mmio_regs;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_we;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        kbd_valid;
    logic [7:0]  kbd_byte;
    logic        disp_valid;
    logic [7:0]  disp_byte;
    logic        disp_done;
    logic        irq;

    int checks = 0;
    int failures = 0;

    localparam logic [31:0] BASE = 32'hFFFF_0000;

    always #2.5 clk = ~clk;

    console_mmio_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kbd_valid(kbd_valid), .kbd_byte(kbd_byte),
        .disp_valid(disp_valid), .disp_byte(disp_byte),
        .disp_done(disp_done), .irq(irq)
    );

    // vector: {write, offset[3:0], wdata[7:0], expected rdata[7:0], expected irq}
    localparam int NV = 12;
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 4'h0, 8'h00, 8'h00, 1'b0},  // R1/R2 rx ctrl at reset
        {1'b0, 4'h8, 8'h00, 8'h01, 1'b0},  // R1/R2 tx ctrl at reset
        {1'b1, 4'h0, 8'h03, 8'h00, 1'b0},  // R8 ready bit not writable
        {1'b0, 4'h0, 8'h00, 8'h02, 1'b0},  // R8 only enable set
        {1'b1, 4'h8, 8'h02, 8'h00, 1'b1},  // R9 tx ready & enable
        {1'b0, 4'h8, 8'h00, 8'h03, 1'b1},  // R2 tx ctrl fields
        {1'b1, 4'h8, 8'hFC, 8'h00, 1'b0},  // R8 bit1 cleared
        {1'b0, 4'h8, 8'h00, 8'h01, 1'b0},
        {1'b1, 4'h0, 8'h00, 8'h00, 1'b0},
        {1'b0, 4'h4, 8'h00, 8'h00, 1'b0},  // R2 rx data empty
        {1'b0, 4'hC, 8'h00, 8'h00, 1'b0},  // R2 tx data reads 0
        {1'b0, 4'h2, 8'h00, 8'h00, 1'b0}   // R10 misaligned reads 0
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge with the bus idle
    task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd);
        bus_sel = 1'b1; bus_we = wr; bus_addr = a; bus_wdata = d;
        #1 rd = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic kbd(input logic [7:0] b);
        kbd_valid = 1'b1; kbd_byte = b;
        @(negedge clk);
        kbd_valid = 1'b0;
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        kbd_valid = 0; kbd_byte = 0; disp_done = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(disp_valid == 0 && irq == 0, "R1 outputs", {disp_valid, irq}, 0);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][21], BASE | 32'(VEC[i][20:17]), 32'(VEC[i][16:9]), rd);
            if (!VEC[i][21])
                check(rd == 32'(VEC[i][8:1]), $sformatf("R2 vec%0d rdata", i), rd, VEC[i][8:1]);
            check(irq == VEC[i][0], $sformatf("R9 vec%0d irq", i), irq, VEC[i][0]);
        end

        // R3 arrival, R9 rx interrupt
        access(1, BASE, 32'h2, rd);
        kbd(8'h41);
        check(irq == 1, "R9 rx irq", irq, 1);
        access(0, BASE, 0, rd);
        check(rd == 32'h3, "R3 rx ready set", rd, 3);
        kbd(8'h42);
        access(0, BASE + 4, 0, rd);
        check(rd == 32'h42, "R3 overwrite byte", rd, 32'h42);
        // R4 cleared after the load
        access(0, BASE, 0, rd);
        check(rd == 32'h2, "R4 ready cleared", rd, 2);
        check(irq == 0, "R9 irq drops", irq, 0);

        // R4 load and arrival in same cycle
        kbd(8'h10);
        kbd_valid = 1; kbd_byte = 8'h77;
        access(0, BASE + 4, 0, rd);
        kbd_valid = 0;
        check(rd == 32'h10, "R4 old byte returned", rd, 32'h10);
        access(0, BASE, 0, rd);
        check(rd[0] == 1, "R4 arrival wins", rd[0], 1);
        access(0, BASE + 4, 0, rd);
        check(rd == 32'h77, "R4 new byte kept", rd, 32'h77);
        access(0, BASE, 0, rd);
        check(rd[0] == 0, "R4 second load clears", rd[0], 0);
        access(1, BASE, 0, rd);

        // R6 done while idle ignored
        disp_done = 1; @(negedge clk); disp_done = 0;
        check(disp_valid == 0, "R6 idle done ignored", disp_valid, 0);

        // R5 send
        access(1, BASE + 12, 32'hABCD_1234, rd);
        check(disp_valid == 1 && disp_byte == 8'h34, "R5 send starts", disp_byte, 8'h34);
        access(0, BASE + 8, 0, rd);
        check(rd[0] == 0, "R5 ready low", rd[0], 0);
        // R7 busy store ignored
        access(1, BASE + 12, 32'h99, rd);
        check(disp_byte == 8'h34 && disp_valid, "R7 byte held", disp_byte, 8'h34);
        // R6 done
        disp_done = 1; @(negedge clk); disp_done = 0;
        check(disp_valid == 0, "R6 valid drops", disp_valid, 0);
        access(0, BASE + 8, 0, rd);
        check(rd[0] == 1, "R6 ready back", rd[0], 1);
        @(negedge clk);
        check(disp_valid == 0, "R7 no second send", disp_valid, 0);

        // R10 out-of-map accesses
        access(1, 32'hFFFF_0018, 32'h2, rd);
        access(1, 32'h0000_0008, 32'h2, rd);
        access(1, BASE + 13, 32'h55, rd);
        check(disp_valid == 0, "R10 no send", disp_valid, 0);
        access(0, BASE + 8, 0, rd);
        check(rd == 32'h1, "R10 enable untouched", rd, 1);
        access(0, 32'hFFFF_0010, 0, rd);
        check(rd == 0, "R10 unmapped reads 0", rd, 0);

        // R1 reset again mid-send
        access(1, BASE + 12, 32'h5A, rd);
        access(1, BASE + 8, 32'h2, rd);
        rst_n = 0; @(negedge clk); rst_n = 1;
        check(disp_valid == 0 && irq == 0, "R1 reset clears", {disp_valid, irq}, 0);
        access(0, BASE + 8, 0, rd);
        check(rd == 32'h1, "R1 tx ctrl after reset", rd, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule